// File: doc/BRIEF.md
# One-Time-Programmable Wiper Setting Controller

This block owns the 8-bit position code of a 256-step digital potentiometer and controls the single permanent storage of that position. Code 0x00 places the wiper at the B end of the ladder, and each increment moves it one tap toward the A end. The block drives only that code to the ladder decoder. Commands arrive already decoded from a serial front end as a valid strobe with a program flag and a data byte. An ordinary write moves the wiper at once. A write with the program flag set also starts a fixed-length fuse-burn sequence, and only one such sequence is ever allowed.

The fuse array is modelled as a register. A per-bit failure mask lets a test make chosen fuses stay unblown. When the burn finishes, the stored code is compared with the requested code, and a two-bit validation code reports ready (00), fatal partial burn (10) or success (11). At power-on the wiper takes the fused code after a successful burn and midscale otherwise. The fuse register and its status survive the ordinary reset. Only a separate fuse-array reset, which stands for a fresh unprogrammed part, clears them.

Top module: `otp_wiper_ctrl`

## Requirements
- R1: When the block is idle, a command with the program flag at 0 puts `cmd_data` on `wiper_code` at the next clock edge, whatever the validation status.
- R2: With validation status 00, the wiper reads 0x80 during reset and after the power-on load.
- R3: With validation status 11, the power-on load puts the fused code on `wiper_code`.
- R4: When the status is 00, a command with the program flag at 1 sets the wiper to `cmd_data` and starts a burn. `busy` then stays high for exactly BURN_CYCLES+1 clock cycles.
- R5: Commands that arrive while `busy` is high have no effect on the wiper, the fuses or the status. `busy` is high during the power-on load and during a burn.
- R6: A burn stores `cmd_data & ~burn_fail_mask`. A mask bit of 1 means that fuse stays unblown and reads 0. The status becomes 11 if the stored code equals the requested code and 10 otherwise. The status never reads 01.
- R7: When the status is not 00, a command with the program flag at 1 is ignored. `busy` stays low, and the wiper and the status keep their values.
- R8: With validation status 10, the power-on load puts 0x80 on the wiper.
- R9: The fuse contents and the status are kept across `rst_n`. Only `fuse_rst_n` clears them, which returns the status to 00.
- R10: After a successful burn, ordinary writes still move the live wiper. The next power-on restores the fused code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset, released synchronously inside the block |
| fuse_rst_n | input | 1 | Asynchronous active-low reset of the fuse model (blank part) |
| cmd_valid | input | 1 | Decoded command strobe |
| cmd_prog | input | 1 | Program flag of the command |
| cmd_data | input | 8 | Requested wiper code |
| burn_fail_mask | input | 8 | Per-bit burn failure injection (1 = fuse stays unblown) |
| wiper_code | output | 8 | Code sent to the ladder decoder |
| busy | output | 1 | Power-on load or burn in progress |
| vstat | output | 2 | Validation code: 00 ready, 10 fatal, 11 done |

## Verification
The burn is tried with three kinds of fail mask. A zero mask must end in success. A random mask that hits set data bits must end in the fatal state. A directed mask that covers only zero data bits must still succeed, which tells a true comparison apart from a check that simply looks for any mask bit. Power cycles are run in each of the three statuses, so the midscale, fused and fallback load paths are each seen. One corner case fuses code 0x00 so that its value cannot be confused with midscale. Random commands are driven throughout every burn, and a second program request follows every burn; together these show that the block admits only one burn attempt.

// File: rtl/otp_wiper_pkg.sv
package otp_wiper_pkg;
  typedef enum logic [1:0] {
    VS_READY = 2'b00,
    VS_FATAL = 2'b10,
    VS_DONE  = 2'b11
  } vstat_e;

  typedef enum logic [1:0] {
    SQ_LOAD,
    SQ_IDLE,
    SQ_BURN,
    SQ_CHECK
  } seq_e;
endpackage

// File: rtl/otp_rst_sync.sv
module otp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/otp_fuse_bank.sv
module otp_fuse_bank
  import otp_wiper_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         fuse_rst_n,
  input  logic         blow_en,
  input  logic [W-1:0] blow_code,
  input  logic [W-1:0] fail_mask,
  input  logic         seal_en,
  input  logic [W-1:0] ref_code,
  output logic [W-1:0] fuse_code,
  output logic [1:0]   vstat
);
  logic [W-1:0] fuse_q, fuse_d, burnt;
  logic         tried_q, tried_d;
  logic         good_q, good_d;

  // each fuse blows only if requested and not forced to fail
  for (genvar i = 0; i < W; i++) begin : g_cell
    assign burnt[i] = blow_code[i] & ~fail_mask[i];
  end

  always_comb begin
    fuse_d  = fuse_q;
    tried_d = tried_q;
    good_d  = good_q;
    if (blow_en && !tried_q) fuse_d = fuse_q | burnt;
    if (seal_en && !tried_q) begin
      tried_d = 1'b1;
      good_d  = (fuse_q == ref_code);
    end
  end

  always_ff @(posedge clk or negedge fuse_rst_n) begin
    if (!fuse_rst_n) begin
      fuse_q  <= '0;
      tried_q <= 1'b0;
      good_q  <= 1'b0;
    end else begin
      fuse_q  <= fuse_d;
      tried_q <= tried_d;
      good_q  <= good_d;
    end
  end

  assign fuse_code = fuse_q;
  assign vstat     = !tried_q ? VS_READY : (good_q ? VS_DONE : VS_FATAL);

  // R9
  fuse_frozen_chk: assert property (@(posedge clk) disable iff (!fuse_rst_n)
    tried_q |=> $stable(fuse_q));
  // R7
  status_sticky_chk: assert property (@(posedge clk) disable iff (!fuse_rst_n)
    (vstat != VS_READY) |=> (vstat == $past(vstat)));
  // R6
  status_code_chk: assert property (@(posedge clk) disable iff (!fuse_rst_n)
    vstat != 2'b01);
endmodule

// File: rtl/otp_burn_seq.sv
module otp_burn_seq
  import otp_wiper_pkg::*;
#(
  parameter int W           = 8,
  parameter int BURN_CYCLES = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_valid,
  input  logic         cmd_prog,
  input  logic [W-1:0] cmd_data,
  input  logic [1:0]   vstat,
  output logic         busy,
  output logic         loading,
  output logic         wr_en,
  output logic         prog_go,
  output logic         blow_en,
  output logic         seal_en,
  output logic [W-1:0] target
);
  localparam int CW = (BURN_CYCLES > 1) ? $clog2(BURN_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(BURN_CYCLES - 1);

  seq_e          st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [W-1:0]  tgt_q, tgt_d;
  logic          accept;

  assign accept  = cmd_valid && (st_q == SQ_IDLE);
  assign wr_en   = accept && !cmd_prog;
  assign prog_go = accept && cmd_prog && (vstat == VS_READY);

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    tgt_d   = tgt_q;
    blow_en = 1'b0;
    seal_en = 1'b0;
    unique case (st_q)
      SQ_LOAD: st_d = SQ_IDLE;
      SQ_IDLE: begin
        if (prog_go) begin
          st_d  = SQ_BURN;
          cnt_d = '0;
          tgt_d = cmd_data;
        end
      end
      SQ_BURN: begin
        if (cnt_q == LAST) begin
          blow_en = 1'b1;
          st_d    = SQ_CHECK;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      SQ_CHECK: begin
        seal_en = 1'b1;
        st_d    = SQ_IDLE;
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_LOAD;
      cnt_q <= '0;
      tgt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      tgt_q <= tgt_d;
    end
  end

  assign busy    = (st_q != SQ_IDLE);
  assign loading = (st_q == SQ_LOAD);
  assign target  = tgt_q;

  // R7
  no_second_burn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_prog && !busy && (vstat != VS_READY)) |=> !busy);
  // R5
  target_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !loading) |=> $stable(target));
endmodule

// File: rtl/otp_wiper_reg.sv
module otp_wiper_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic [W-1:0] load_code,
  input  logic         wr_en,
  input  logic [W-1:0] wr_code,
  output logic [W-1:0] code
);
  localparam logic [W-1:0] MID = W'(1) << (W - 1);

  logic [W-1:0] code_q, code_d;

  always_comb begin
    code_d = code_q;
    if (load_en)    code_d = load_code;
    else if (wr_en) code_d = wr_code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= MID;
    else        code_q <= code_d;
  end

  assign code = code_q;
endmodule

// File: rtl/otp_wiper_ctrl.sv
module otp_wiper_ctrl
  import otp_wiper_pkg::*;
#(
  parameter int W           = 8,
  parameter int BURN_CYCLES = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fuse_rst_n,
  input  logic         cmd_valid,
  input  logic         cmd_prog,
  input  logic [W-1:0] cmd_data,
  input  logic [W-1:0] burn_fail_mask,
  output logic [W-1:0] wiper_code,
  output logic         busy,
  output logic [1:0]   vstat
);
  localparam logic [W-1:0] MID = W'(1) << (W - 1);

  logic         rst_s_n;
  logic         loading, wr_en, prog_go, blow_en, seal_en;
  logic [W-1:0] target, fuse_code, load_code;

  otp_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_s_n)
  );

  otp_burn_seq #(.W(W), .BURN_CYCLES(BURN_CYCLES)) u_seq (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .cmd_valid (cmd_valid),
    .cmd_prog  (cmd_prog),
    .cmd_data  (cmd_data),
    .vstat     (vstat),
    .busy      (busy),
    .loading   (loading),
    .wr_en     (wr_en),
    .prog_go   (prog_go),
    .blow_en   (blow_en),
    .seal_en   (seal_en),
    .target    (target)
  );

  otp_fuse_bank #(.W(W)) u_fuse (
    .clk        (clk),
    .fuse_rst_n (fuse_rst_n),
    .blow_en    (blow_en),
    .blow_code  (target),
    .fail_mask  (burn_fail_mask),
    .seal_en    (seal_en),
    .ref_code   (target),
    .fuse_code  (fuse_code),
    .vstat      (vstat)
  );

  assign load_code = (vstat == VS_DONE) ? fuse_code : MID;

  otp_wiper_reg #(.W(W)) u_wiper (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .load_en   (loading),
    .load_code (load_code),
    .wr_en     (wr_en | prog_go),
    .wr_code   (cmd_data),
    .code      (wiper_code)
  );

  // R5
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (busy && !loading) |=> $stable(wiper_code));
  // R2
  mid_load_chk: assert property (@(posedge clk) disable iff (!rst_s_n || !fuse_rst_n)
    (loading && (vstat != VS_DONE)) |=> (wiper_code == MID));
  // R3
  fused_load_chk: assert property (@(posedge clk) disable iff (!rst_s_n || !fuse_rst_n)
    (loading && (vstat == VS_DONE)) |=> (wiper_code == $past(fuse_code)));
endmodule

// File: tb/otp_wiper_ctrl_tb.sv
module otp_wiper_ctrl_tb_top;
  localparam int NB = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fuse_rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_prog = 1'b0;
  logic [7:0] cmd_data = '0;
  logic [7:0] burn_fail_mask = '0;
  logic [7:0] wiper_code;
  logic       busy;
  logic [1:0] vstat;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  logic [7:0] m_fuse = '0;
  logic [1:0] m_stat = 2'b00;
  logic [7:0] m_wiper = 8'h80;

  always #2.5 clk = ~clk;

  otp_wiper_ctrl #(.W(8), .BURN_CYCLES(NB)) dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .fuse_rst_n     (fuse_rst_n),
    .cmd_valid      (cmd_valid),
    .cmd_prog       (cmd_prog),
    .cmd_data       (cmd_data),
    .burn_fail_mask (burn_fail_mask),
    .wiper_code     (wiper_code),
    .busy           (busy),
    .vstat          (vstat)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [7:0] exp_fuse(input logic [7:0] d, input logic [7:0] m);
    return d & ~m;
  endfunction

  function automatic logic [1:0] exp_stat(input logic [7:0] d, input logic [7:0] m);
    return (exp_fuse(d, m) == d) ? 2'b11 : 2'b10;
  endfunction

  function automatic logic [7:0] exp_load(input logic [1:0] s, input logic [7:0] f);
    return (s == 2'b11) ? f : 8'h80;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total = total + 1;
    if (act != exp) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 100) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic cmd(input logic p, input logic [7:0] d);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_prog  = p;
    cmd_data  = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_prog  = 1'b0;
  endtask

  task automatic power(input logic blank);
    int n;
    @(negedge clk);
    rst_n = 1'b0;
    if (blank) fuse_rst_n = 1'b0;
    @(negedge clk);
    if (blank) begin
      m_fuse = '0;
      m_stat = 2'b00;
      chk("R2 reset wiper", wiper_code, 8'h80);
      chk("R9 blank status", vstat, 2'b00);
    end
    rst_n = 1'b1;
    fuse_rst_n = 1'b1;
    @(negedge clk);
    wait_idle(n);
    m_wiper = exp_load(m_stat, m_fuse);
    chk("R9 status kept", vstat, m_stat);
    if (m_stat == 2'b11)      chk("R3 fused load", wiper_code, m_wiper);
    else if (m_stat == 2'b10) chk("R8 fatal load", wiper_code, m_wiper);
    else                      chk("R2 mid load", wiper_code, m_wiper);
  endtask

  task automatic write(input logic [7:0] d);
    cmd(1'b0, d);
    m_wiper = d;
    chk("R1 write", wiper_code, m_wiper);
    if (m_stat == 2'b11) chk("R10 live write", wiper_code, d);
  endtask

  task automatic burn(input logic [7:0] d, input logic [7:0] m, input logic noise);
    int n;
    burn_fail_mask = m;
    cmd(1'b1, d);
    if (m_stat == 2'b00) begin
      n = 0;
      while (busy && n < 100) begin
        n++;
        cmd_valid = noise;
        cmd_prog  = 1'($urandom);
        cmd_data  = 8'($urandom);
        @(negedge clk);
      end
      cmd_valid = 1'b0;
      cmd_prog  = 1'b0;
      chk("R4 busy length", n, NB + 1);
      m_wiper = d;
      m_fuse  = exp_fuse(d, m);
      m_stat  = exp_stat(d, m);
      chk("R5 wiper after busy cmds", wiper_code, m_wiper);
      chk("R6 burn status", vstat, m_stat);
    end else begin
      chk("R7 no busy", busy, 0);
      chk("R7 wiper kept", wiper_code, m_wiper);
      chk("R7 status kept", vstat, m_stat);
    end
    burn_fail_mask = '0;
  endtask

  initial begin
    void'($urandom(32'h1d2c));
    // R2: blank part powers up at midscale
    power(1'b1);
    write(8'h00);
    write(8'hFF);
    // R6: mask hits only zero data bits, still a success
    burn(8'h0F, 8'hF0, 1'b1);
    power(1'b0);
    // R7: second request after success
    burn(8'h55, 8'h00, 1'b0);
    // R10: live write then power restores fuse
    write(8'h33);
    power(1'b0);
    // corner: fuse 0x00 with all fuses failing
    power(1'b1);
    burn(8'h00, 8'hFF, 1'b0);
    power(1'b0);
    // R8: fatal state
    power(1'b1);
    burn(8'hA5, 8'h01, 1'b1);
    burn(8'h11, 8'h00, 1'b0);
    write(8'h42);
    power(1'b0);
    for (int it = 0; it < 30; it++) begin
      logic [7:0] d, m;
      power(1'b1);
      for (int k = 0; k < 3; k++) write(8'($urandom));
      d = 8'($urandom);
      m = ($urandom % 2 == 0) ? 8'h00 : 8'($urandom);
      burn(d, m, 1'b1);
      write(8'($urandom));
      burn(8'($urandom), 8'h00, 1'b0);
      power(1'b0);
      write(8'($urandom));
      power(1'b0);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule